// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Interlock

This block holds the hazard control of a five-stage integer pipeline: fetch, decode, execute, memory and write-back. From the register numbers of the instructions in decode and in execute, and from the destination, write-enable and load flags held in the three inter-stage registers, it decides where each ALU operand comes from. It also decides whether the store data entering the data memory must be taken from the write-back stage. When a load is followed at once by an instruction that needs the loaded value as an ALU operand, it raises a stall for exactly one cycle.

The operand selects are combinational and valid in the same cycle as their inputs. The surrounding pipeline uses `stall` to hold the program counter and the fetch/decode register, and to load an empty slot into the decode/execute register. The stall control is a two-state machine. In state `ST_RUN` the stall follows the load-use detector. Transition `T_HAZARD` moves it to `ST_BUBBLE` on the edge at which a stall was raised. In `ST_BUBBLE` the stall is held low. Transition `T_RESUME` always returns it to `ST_RUN` on the next edge. Transition `T_CONTINUE` keeps it in `ST_RUN` when there is no hazard.

Top module: `fwd_interlock_unit`

## Requirements
- R1: For each ALU source (`fwd_a` for execute source 1, `fwd_b` for execute source 2), when the execute/memory producer has its write-enable high, a nonzero destination, and that destination equals the source number, the select is 2'b10.
- R2: When the execute/memory producer does not match a source but the memory/write-back producer does (write-enable high, nonzero destination equal to the source), the select is 2'b01.
- R3: When both producers match the same source, the execute/memory value wins and the select is 2'b10.
- R4: A source numbered 0, or one whose only matching producers have write-enable low, gets select 2'b00 (register file).
- R5: `st_fwd` is 1 exactly when the instruction in the memory stage is a store (`mem_store`=1) and its data register equals the nonzero, write-enabled memory/write-back destination. Otherwise it is 0.
- R6: In `ST_RUN`, `stall` is 1 when decode/execute holds a load with write-enable high and a nonzero destination, and that destination equals decode source 1, or equals decode source 2 of an instruction that is not a store.
- R7: A store in decode whose only match with the pending load is its data register (source 2) causes no stall, because that value reaches memory through `st_fwd`.
- R8: A producer in decode/execute that is not a load, or a load with destination 0 or write-enable low, never causes a stall.
- R9: A stall lasts exactly one cycle: in the cycle after `stall` was 1, `stall` is 0 whatever the inputs are.
- R10: Reset puts the machine in `ST_RUN`, so a load-use hazard presented in the first cycle after reset is stalled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| id_src1 | input | AW | Decode-stage source register 1 |
| id_src2 | input | AW | Decode-stage source register 2 |
| id_store | input | 1 | Decode instruction is a store (source 2 is store data) |
| ex_src1 | input | AW | Execute-stage source register 1 (ALU input A) |
| ex_src2 | input | AW | Execute-stage source register 2 (ALU input B) |
| idex_dst | input | AW | Destination held in decode/execute |
| idex_we | input | 1 | Register write-enable held in decode/execute |
| idex_load | input | 1 | Decode/execute holds a load |
| exmem_dst | input | AW | Destination held in execute/memory |
| exmem_we | input | 1 | Register write-enable held in execute/memory |
| mem_store | input | 1 | Memory-stage instruction is a store |
| mem_src2 | input | AW | Store-data register of the memory-stage instruction |
| memwb_dst | input | AW | Destination held in memory/write-back |
| memwb_we | input | 1 | Register write-enable held in memory/write-back |
| fwd_a | output | 2 | ALU input A select: 00 file, 10 exec/mem, 01 mem/wb |
| fwd_b | output | 2 | ALU input B select, same encoding |
| st_fwd | output | 1 | Store data taken from the write-back value |
| stall | output | 1 | Hold PC and fetch/decode, empty slot into decode/execute |

## Verification
The selects `fwd_a`, `fwd_b` and `st_fwd`, and the stall decision in `ST_RUN`, are due in the same cycle as the inputs that cause them. The state change to `ST_BUBBLE` takes effect after the next rising edge, so the one-cycle stall limit shows in the cycle after. The bench changes its inputs at the falling edge and compares 1 ns later, well before the next rising edge. Its reference model of the previous stall advances only at the rising edge, which matches the single register on the path.

// File: rtl/fih_pkg.sv
package fih_pkg;

    typedef enum logic [1:0] {
        SEL_REGFILE = 2'b00,
        SEL_WB      = 2'b01,
        SEL_MEM     = 2'b10
    } opnd_sel_e;

    typedef enum logic {
        ST_RUN    = 1'b0,
        ST_BUBBLE = 1'b1
    } ilk_state_e;

endpackage

// File: rtl/fih_match.sv
// Tells whether one producer stage will write the given source register.
module fih_match #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] dst,
    input  logic          we,
    output logic          hit
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    always_comb begin
        hit = we && (dst != ZERO_REG) && (dst == src);
    end
endmodule

// File: rtl/fih_opnd_sel.sv
// Selects the source of one ALU operand; the nearer producer wins.
module fih_opnd_sel
    import fih_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] exmem_dst,
    input  logic          exmem_we,
    input  logic [AW-1:0] memwb_dst,
    input  logic          memwb_we,
    output opnd_sel_e     sel
);
    logic hit_mem;
    logic hit_wb;

    fih_match #(.AW(AW)) u_hit_mem (
        .src (src),
        .dst (exmem_dst),
        .we  (exmem_we),
        .hit (hit_mem)
    );

    fih_match #(.AW(AW)) u_hit_wb (
        .src (src),
        .dst (memwb_dst),
        .we  (memwb_we),
        .hit (hit_wb)
    );

    always_comb begin
        if (hit_mem) begin
            sel = SEL_MEM;
        end else if (hit_wb) begin
            sel = SEL_WB;
        end else begin
            sel = SEL_REGFILE;
        end
    end
endmodule

// File: rtl/fih_load_use.sv
// Detects a load in decode/execute whose result the decode instruction needs in the ALU.
module fih_load_use #(
    parameter int AW = 5
) (
    input  logic [AW-1:0] id_src1,
    input  logic [AW-1:0] id_src2,
    input  logic          id_store,
    input  logic [AW-1:0] idex_dst,
    input  logic          idex_we,
    input  logic          idex_load,
    output logic          hazard
);
    logic hit1;
    logic hit2;
    logic producer_is_load;

    fih_match #(.AW(AW)) u_hit1 (
        .src (id_src1),
        .dst (idex_dst),
        .we  (idex_we),
        .hit (hit1)
    );

    fih_match #(.AW(AW)) u_hit2 (
        .src (id_src2),
        .dst (idex_dst),
        .we  (idex_we),
        .hit (hit2)
    );

    always_comb begin
        producer_is_load = idex_load;
        // A store's source 2 is data only; it is served by the store-data path.
        hazard = producer_is_load && (hit1 || (hit2 && !id_store));
    end
endmodule

// File: rtl/fih_stall_fsm.sv
// Limits every load-use stall to a single bubble.
module fih_stall_fsm
    import fih_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hazard,
    output logic stall
);
    ilk_state_e state_q;
    ilk_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        stall   = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                stall = hazard;
                if (hazard) begin
                    state_d = ST_BUBBLE;   // T_HAZARD
                end else begin
                    state_d = ST_RUN;      // T_CONTINUE
                end
            end
            ST_BUBBLE: begin
                stall   = 1'b0;
                state_d = ST_RUN;          // T_RESUME
            end
            default: begin
                stall   = 1'b0;
                state_d = ST_RUN;
            end
        endcase
    end
endmodule

// File: rtl/fwd_interlock_unit.sv
module fwd_interlock_unit
    import fih_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] id_src1,
    input  logic [AW-1:0] id_src2,
    input  logic          id_store,
    input  logic [AW-1:0] ex_src1,
    input  logic [AW-1:0] ex_src2,
    input  logic [AW-1:0] idex_dst,
    input  logic          idex_we,
    input  logic          idex_load,
    input  logic [AW-1:0] exmem_dst,
    input  logic          exmem_we,
    input  logic          mem_store,
    input  logic [AW-1:0] mem_src2,
    input  logic [AW-1:0] memwb_dst,
    input  logic          memwb_we,
    output logic [1:0]    fwd_a,
    output logic [1:0]    fwd_b,
    output logic          st_fwd,
    output logic          stall
);
    localparam int NUM_SRC = 2;

    logic [AW-1:0] ex_src  [NUM_SRC];
    opnd_sel_e     src_sel [NUM_SRC];
    logic          st_hit;
    logic          ld_hazard;

    assign ex_src[0] = ex_src1;
    assign ex_src[1] = ex_src2;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_opnd
        fih_opnd_sel #(.AW(AW)) u_sel (
            .src       (ex_src[g]),
            .exmem_dst (exmem_dst),
            .exmem_we  (exmem_we),
            .memwb_dst (memwb_dst),
            .memwb_we  (memwb_we),
            .sel       (src_sel[g])
        );
    end

    assign fwd_a = src_sel[0];
    assign fwd_b = src_sel[1];

    // Store data in the memory stage may come from the write-back value.
    fih_match #(.AW(AW)) u_store_hit (
        .src (mem_src2),
        .dst (memwb_dst),
        .we  (memwb_we),
        .hit (st_hit)
    );

    assign st_fwd = mem_store && st_hit;

    fih_load_use #(.AW(AW)) u_load_use (
        .id_src1   (id_src1),
        .id_src2   (id_src2),
        .id_store  (id_store),
        .idex_dst  (idex_dst),
        .idex_we   (idex_we),
        .idex_load (idex_load),
        .hazard    (ld_hazard)
    );

    fih_stall_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .hazard (ld_hazard),
        .stall  (stall)
    );
endmodule

// File: rtl/fih_checker.sv
module fih_checker #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] id_src1,
    input logic [AW-1:0] id_src2,
    input logic          id_store,
    input logic [AW-1:0] ex_src1,
    input logic [AW-1:0] ex_src2,
    input logic [AW-1:0] idex_dst,
    input logic          idex_we,
    input logic          idex_load,
    input logic [AW-1:0] exmem_dst,
    input logic          exmem_we,
    input logic          mem_store,
    input logic [AW-1:0] mem_src2,
    input logic [AW-1:0] memwb_dst,
    input logic          memwb_we,
    input logic [1:0]    fwd_a,
    input logic [1:0]    fwd_b,
    input logic          st_fwd,
    input logic          stall
);
    localparam logic [AW-1:0] Z = '0;

    p_mem_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (exmem_we && exmem_dst != Z && exmem_dst == ex_src1) |-> fwd_a == 2'b10);

    p_mem_first_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (exmem_we && exmem_dst != Z && exmem_dst == ex_src2) |-> fwd_b == 2'b10);

    p_wb_second_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(exmem_we && exmem_dst == ex_src1) && memwb_we && memwb_dst != Z
         && memwb_dst == ex_src1) |-> fwd_a == 2'b01);

    p_zero_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_src1 == Z) |-> fwd_a == 2'b00);

    p_store_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_fwd |-> (mem_store && memwb_we && mem_src2 == memwb_dst && memwb_dst != Z));

    p_stall_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (idex_load && idex_we && idex_dst != Z &&
                   (id_src1 == idex_dst || (id_src2 == idex_dst && !id_store))));

    p_store_no_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (id_store && id_src1 != idex_dst) |-> !stall);

    p_no_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !idex_load |-> !stall);

    p_one_bubble_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> !stall);
endmodule

bind fwd_interlock_unit fih_checker #(.AW(AW)) u_chk (.*);

// File: tb/fwd_interlock_unit_tb.sv
`timescale 1ns/1ps
module fwd_interlock_unit_tb;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] id_src1 = '0, id_src2 = '0, ex_src1 = '0, ex_src2 = '0;
    logic [AW-1:0] idex_dst = '0, exmem_dst = '0, mem_src2 = '0, memwb_dst = '0;
    logic          id_store = 0, idex_we = 0, idex_load = 0, exmem_we = 0;
    logic          mem_store = 0, memwb_we = 0;
    logic [1:0]    fwd_a, fwd_b;
    logic          st_fwd, stall;

    int n_chk = 0;
    int n_bad = 0;
    logic prev_stall = 1'b0;
    logic exp_stall;
    bit done = 0;

    always #4 clk = ~clk;

    fwd_interlock_unit #(.AW(AW)) u_dut (.*);

    function automatic logic [1:0] ref_sel(input logic [AW-1:0] s);
        if (exmem_we && exmem_dst != 0 && exmem_dst == s) return 2'b10;
        if (memwb_we && memwb_dst != 0 && memwb_dst == s) return 2'b01;
        return 2'b00;
    endfunction

    function automatic string sel_tag(input logic [AW-1:0] s);
        logic m, w;
        m = exmem_we && exmem_dst != 0 && exmem_dst == s;
        w = memwb_we && memwb_dst != 0 && memwb_dst == s;
        if (m && w) return "R3";
        if (m) return "R1";
        if (w) return "R2";
        return "R4";
    endfunction

    function automatic logic ref_store();
        return mem_store && memwb_we && memwb_dst != 0 && mem_src2 == memwb_dst;
    endfunction

    function automatic logic ref_hazard();
        return idex_load && idex_we && idex_dst != 0 &&
               (id_src1 == idex_dst || (id_src2 == idex_dst && !id_store));
    endfunction

    function automatic string stall_tag();
        if (ref_hazard()) return prev_stall ? "R9" : "R6";
        if (id_store && idex_load && idex_we && idex_dst != 0 && id_src2 == idex_dst) return "R7";
        return "R8";
    endfunction

    task automatic check(input string tag, input logic [1:0] got, input logic [1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    // Inputs are already set (after a falling edge); compare, then advance model at the rising edge.
    task automatic compare_and_tick();
        #1;
        exp_stall = ref_hazard() && !prev_stall;
        check(sel_tag(ex_src1), fwd_a, ref_sel(ex_src1));
        check(sel_tag(ex_src2), fwd_b, ref_sel(ex_src2));
        check("R5", {1'b0, st_fwd}, {1'b0, ref_store()});
        check(stall_tag(), {1'b0, stall}, {1'b0, exp_stall});
        @(posedge clk);
        prev_stall = exp_stall;
        @(negedge clk);
    endtask

    task automatic clear_inputs();
        id_src1 = 0; id_src2 = 0; id_store = 0; ex_src1 = 0; ex_src2 = 0;
        idex_dst = 0; idex_we = 0; idex_load = 0; exmem_dst = 0; exmem_we = 0;
        mem_store = 0; mem_src2 = 0; memwb_dst = 0; memwb_we = 0;
    endtask

    initial begin
        #(64'd8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        @(negedge clk);
        // Reset state: quiet inputs give register-file selects and no stall.
        #1;
        check("R4", fwd_a, 2'b00);
        check("R10", {1'b0, stall}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: hazard in the first cycle after reset stalls; R9: the next cycle does not.
        idex_load = 1; idex_we = 1; idex_dst = 5'd7; id_src1 = 5'd7;
        #1; check("R10", {1'b0, stall}, 2'b01); #0;
        @(posedge clk); prev_stall = 1'b1; @(negedge clk);
        #1; check("R9", {1'b0, stall}, 2'b00);
        @(posedge clk); prev_stall = 1'b0; @(negedge clk);
        clear_inputs();

        // R1, R2, R3, R4 directed: add then dependent ALU ops.
        ex_src1 = 5'd1; ex_src2 = 5'd2; exmem_dst = 5'd1; exmem_we = 1;
        memwb_dst = 5'd2; memwb_we = 1;
        #1; check("R1", fwd_a, 2'b10); check("R2", fwd_b, 2'b01); #0;
        @(negedge clk);
        memwb_dst = 5'd1;
        #1; check("R3", fwd_a, 2'b10); #0;
        @(negedge clk);
        ex_src1 = 0; exmem_dst = 0; memwb_dst = 0;
        #1; check("R4", fwd_a, 2'b00); #0;
        @(negedge clk);
        ex_src1 = 5'd3; exmem_dst = 5'd3; exmem_we = 0; memwb_dst = 5'd3; memwb_we = 0;
        #1; check("R4", fwd_a, 2'b00); #0;
        @(negedge clk);
        clear_inputs();

        // R7: load then store of the loaded register as data: no stall. R5: data forwarded later.
        idex_load = 1; idex_we = 1; idex_dst = 5'd4; id_store = 1; id_src1 = 5'd1; id_src2 = 5'd4;
        #1; check("R7", {1'b0, stall}, 2'b00); #0;
        @(negedge clk);
        clear_inputs();
        mem_store = 1; mem_src2 = 5'd4; memwb_dst = 5'd4; memwb_we = 1;
        #1; check("R5", {1'b0, st_fwd}, 2'b01); #0;
        @(negedge clk);
        mem_store = 0;
        #1; check("R5", {1'b0, st_fwd}, 2'b00); #0;
        @(negedge clk);
        clear_inputs();

        // R8: ALU producer or load to register 0 does not stall.
        idex_we = 1; idex_dst = 5'd6; id_src1 = 5'd6;
        #1; check("R8", {1'b0, stall}, 2'b00); #0;
        @(negedge clk);
        idex_load = 1; idex_dst = 0; id_src1 = 0;
        #1; check("R8", {1'b0, stall}, 2'b00); #0;
        @(negedge clk);
        clear_inputs();
        prev_stall = 1'b0;

        // Constrained random traffic over a small register set to provoke matches.
        for (int i = 0; i < 4000; i++) begin
            id_src1   = AW'($urandom_range(0, 3));
            id_src2   = AW'($urandom_range(0, 3));
            id_store  = 1'($urandom_range(0, 1));
            ex_src1   = AW'($urandom_range(0, 3));
            ex_src2   = AW'($urandom_range(0, 3));
            idex_dst  = AW'($urandom_range(0, 3));
            idex_we   = ($urandom_range(0, 3) != 0);
            idex_load = 1'($urandom_range(0, 1));
            exmem_dst = AW'($urandom_range(0, 3));
            exmem_we  = 1'($urandom_range(0, 1));
            mem_store = 1'($urandom_range(0, 1));
            mem_src2  = AW'($urandom_range(0, 3));
            memwb_dst = AW'($urandom_range(0, 3));
            memwb_we  = 1'($urandom_range(0, 1));
            compare_and_tick();
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule